// File: doc/BRIEF.md
# Step and Direction Pulse Sequencer

This block drives the step and direction lines of one motor axis. Each accepted step request produces one step. The direction line is updated first. A step pulse follows, and the step line is active low and rests high. Every step takes two equal intervals whose length comes from a programmable count of clock cycles. Depending on the alignment mode, the direction setup and hold window sits either around the falling edge of the step pulse or around its rising edge.

An optional slow-driver mode adds two things. After a direction reversal, the block waits a fixed 50 µs before the first step. Every interval is also forced to 2 µs. Both lengths are derived from the clock frequency parameter. A request that arrives while a step is in progress is held in a single slot and started as soon as the current step ends, so back-to-back steps keep a constant period. A disable input keeps the step line at its resting level without changing the timing of the sequence.

Top module: `step_dir_sequencer`

## Requirements
- R1: After reset, step_o is 1, dir_o is 0 and busy_o is 0.
- R2: Leading alignment (align_trail_i = 0). A request accepted at clock edge A with interval length W drives step_o low from edge A+W to edge A+2W. busy_o is 1 from A and falls at A+2W.
- R3: Trailing alignment (align_trail_i = 1). step_o is low from edge A to edge A+W. busy_o falls at A+2W.
- R4: dir_o takes the requested direction at the acceptance edge A. It does not change while step_o is low.
- R5: With delay_en_i = 1, if the requested direction differs from the current dir_o, both step phases start CLK_HZ/20000 cycles later. If the direction is the same, no wait is added.
- R6: With delay_en_i = 1, W is CLK_HZ/500000 cycles, whatever the value of pulse_width_i.
- R7: With delay_en_i = 0, W equals pulse_width_i. A value of 0 is treated as 1.
- R8: A request made while busy_o is 1 is kept, together with the direction present on that request, and is accepted at the edge where the current step ends. This leaves no idle cycle between the two steps. Later changes of dir_i do not alter it.
- R9: While step_dis_i is 1, step_o is 1 from the next edge onward. busy_o and dir_o follow the same timing as when enabled.
- R10: W and the alignment mode are sampled at acceptance. Changes to them during a step have no effect on that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_req_i | input | 1 | One-cycle step request strobe |
| dir_i | input | 1 | Direction for the request |
| pulse_width_i | input | PW_W | Interval length in clock cycles |
| delay_en_i | input | 1 | Slow-driver mode: reversal wait and fixed 2 µs intervals |
| align_trail_i | input | 1 | 0: window around the falling edge, 1: around the rising edge |
| step_dis_i | input | 1 | Hold step_o at its resting level |
| step_o | output | 1 | Step line, active low |
| dir_o | output | 1 | Direction line |
| busy_o | output | 1 | A step sequence is running |

## Verification
The disable input and a pulse already in progress can act in the same cycle. The bench starts a 10-cycle pulse in leading alignment and raises step_dis_i partway through it. The scoreboard then requires a rising edge on step_o at the exact edge after disable is sampled, and no second rising edge at the end of the pulse. It also requires busy_o to fall at the originally planned edge. A second coincidence is covered by the queued-request case: a held request must start on the same edge at which the running step ends.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PH1  = 2'd2,
        ST_PH2  = 2'd3
    } sds_state_e;

endpackage

// File: rtl/sds_len_sel.sv
module sds_len_sel #(
    parameter int unsigned PW_W    = 12,
    parameter int unsigned LEN_W   = 13,
    parameter int unsigned FIX_CYC = 250
) (
    input  logic [PW_W-1:0]  pulse_width_i,
    input  logic             fixed_i,
    output logic [LEN_W-1:0] len_o
);

    always_comb begin
        if (fixed_i) begin
            len_o = LEN_W'(FIX_CYC);
        end else if (pulse_width_i == '0) begin
            len_o = LEN_W'(1);
        end else begin
            len_o = LEN_W'(pulse_width_i);
        end
    end

    // R7: an interval is never zero cycles long
    always_comb begin
        assert_len_nonzero_R7: assert (len_o != '0)
            else $error("interval length is zero");
    end

endmodule

// File: rtl/step_dir_sequencer.sv
module step_dir_sequencer
    import sds_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int unsigned PW_W   = 12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            step_req_i,
    input  logic            dir_i,
    input  logic [PW_W-1:0] pulse_width_i,
    input  logic            delay_en_i,
    input  logic            align_trail_i,
    input  logic            step_dis_i,
    output logic            step_o,
    output logic            dir_o,
    output logic            busy_o
);

    localparam int unsigned FIX_CYC  = (CLK_HZ / 500_000 > 0) ? CLK_HZ / 500_000 : 1;
    localparam int unsigned DLY_CYC  = (CLK_HZ / 20_000 > 0) ? CLK_HZ / 20_000 : 1;
    localparam int unsigned DLY_BITS = $clog2(DLY_CYC + 1);
    localparam int unsigned FIX_BITS = $clog2(FIX_CYC + 1);
    localparam int unsigned CNT_A    = (PW_W > DLY_BITS) ? PW_W : DLY_BITS;
    localparam int unsigned CNT_W    = (CNT_A > FIX_BITS) ? CNT_A : FIX_BITS;

    typedef struct packed {
        sds_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic             trail;
        logic             dir;
        logic             step;
        logic             pend;
        logic             pend_dir;
    } sds_regs_t;

    sds_regs_t        r_q, r_d;
    logic [CNT_W-1:0] len_new;
    logic             start;
    logic             start_dir;
    logic             pulse_nxt;

    sds_len_sel #(
        .PW_W    (PW_W),
        .LEN_W   (CNT_W),
        .FIX_CYC (FIX_CYC)
    ) u_len (
        .pulse_width_i (pulse_width_i),
        .fixed_i       (delay_en_i),
        .len_o         (len_new)
    );

    always_comb begin
        r_d       = r_q;
        start     = 1'b0;
        start_dir = dir_i;

        if (r_q.st == ST_IDLE) begin
            start = step_req_i;
        end else begin
            if (step_req_i) begin
                r_d.pend     = 1'b1;
                r_d.pend_dir = dir_i;
            end
            if (r_q.cnt != '0) begin
                r_d.cnt = r_q.cnt - 1'b1;
            end else begin
                unique case (r_q.st)
                    ST_WAIT: begin
                        r_d.st  = ST_PH1;
                        r_d.cnt = r_q.len - 1'b1;
                    end
                    ST_PH1: begin
                        r_d.st  = ST_PH2;
                        r_d.cnt = r_q.len - 1'b1;
                    end
                    ST_PH2: begin
                        if (r_q.pend) begin
                            start     = 1'b1;
                            start_dir = r_q.pend_dir;
                            r_d.pend  = step_req_i;
                        end else if (step_req_i) begin
                            start    = 1'b1;
                            r_d.pend = 1'b0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end

        if (start) begin
            r_d.dir   = start_dir;
            r_d.len   = len_new;
            r_d.trail = align_trail_i;
            if (delay_en_i && (start_dir != r_q.dir)) begin
                r_d.st  = ST_WAIT;
                r_d.cnt = CNT_W'(DLY_CYC - 1);
            end else begin
                r_d.st  = ST_PH1;
                r_d.cnt = len_new - 1'b1;
            end
        end

        pulse_nxt = ((r_d.st == ST_PH1) &&  r_d.trail) ||
                    ((r_d.st == ST_PH2) && !r_d.trail);
        r_d.step  = !pulse_nxt || step_dis_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.step     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o = r_q.step;
    assign dir_o  = r_q.dir;
    assign busy_o = (r_q.st != ST_IDLE);

    // R1: idle means the step line rests high
    assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> step_o);

    // R2: a low step line only occurs inside a running sequence
    assert_low_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_o |-> busy_o);

    // R4: direction is frozen while the pulse is low
    assert_dir_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_o && $past(!step_o)) |-> $stable(dir_o));

    // R9: a sampled disable forces the resting level
    assert_dis_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(step_dis_i) |-> step_o);

    // R8: a held request never outlives an idle state
    assert_pend_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.pend |-> busy_o);

endmodule

// File: tb/step_dir_sequencer_bench.sv
module step_dir_sequencer_bench;

    localparam int unsigned CLK_HZ = 125_000_000;
    localparam int unsigned PW_W   = 12;
    localparam int          FIX    = CLK_HZ / 500_000;
    localparam int          DLY    = CLK_HZ / 20_000;

    typedef struct {
        int   cyc;
        logic lvl;
        logic dir;
        string req;
    } ev_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic            dir_in = 1'b0;
    logic [PW_W-1:0] pw = '0;
    logic            den = 1'b0;
    logic            trl = 1'b0;
    logic            dis = 1'b0;
    logic            step_o, dir_o, busy_o;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   free_at = 0;
    logic mdir = 1'b0;
    bit   mon_on = 1'b0;
    logic prev_step = 1'b1;
    ev_t  exp_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    step_dir_sequencer #(.CLK_HZ(CLK_HZ), .PW_W(PW_W)) u_step_dir_sequencer (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .step_req_i    (req),
        .dir_i         (dir_in),
        .pulse_width_i (pw),
        .delay_en_i    (den),
        .align_trail_i (trl),
        .step_dis_i    (dis),
        .step_o        (step_o),
        .dir_o         (dir_o),
        .busy_o        (busy_o)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic push_ev(input int c, input logic l, input logic d, input string rq);
        ev_t e;
        e.cyc = c; e.lvl = l; e.dir = d; e.req = rq;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor: every step_o edge must match the next expected item
    always @(negedge clk) begin
        if (mon_on && (step_o !== prev_step)) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected step edge", int'(step_o), int'(prev_step));
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk({e.req, " edge cycle"}, cyc, e.cyc);
                chk({e.req, " edge level"}, int'(step_o), int'(e.lvl));
                if (!e.lvl) chk("R4 dir at step fall", int'(dir_o), int'(e.dir));
            end
        end
        prev_step = step_o;
    end

    // driver: issues one request, predicts its edges from the requirements
    task automatic issue(input logic d, input logic t, input int w, input logic de,
                         input bit nopush, input string rq, output int acc);
        int weff, hold, a;
        @(negedge clk);
        dir_in = d; trl = t; pw = PW_W'(w); den = de; req = 1'b1;
        a    = (free_at > cyc + 1) ? free_at : cyc + 1;
        weff = de ? FIX : ((w == 0) ? 1 : w);
        hold = (de && (d != mdir)) ? DLY : 0;
        mdir = d;
        if (!nopush && !dis) begin
            if (t) begin
                push_ev(a + hold, 1'b0, d, rq);
                push_ev(a + hold + weff, 1'b1, d, rq);
            end else begin
                push_ev(a + hold + weff, 1'b0, d, rq);
                push_ev(a + hold + 2 * weff, 1'b1, d, rq);
            end
        end
        free_at = a + hold + 2 * weff;
        acc = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        while (cyc < free_at - 1) @(negedge clk);
        chk({rq, " busy before end"}, int'(busy_o), 1);
        @(negedge clk);
        chk({rq, " busy after end"}, int'(busy_o), 0);
    endtask

    initial begin
        int a, a2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 step_o", int'(step_o), 1);
        chk("R1 dir_o", int'(dir_o), 0);
        chk("R1 busy_o", int'(busy_o), 0);
        prev_step = step_o;
        mon_on = 1'b1;

        // R2 leading alignment, R4 dir at acceptance
        issue(1'b1, 1'b0, 5, 1'b0, 0, "R2", a);
        chk("R4 dir after accept", int'(dir_o), 1);
        chk("R2 busy after accept", int'(busy_o), 1);
        wait_done("R2");

        // R3 trailing alignment
        issue(1'b0, 1'b1, 7, 1'b0, 0, "R3", a);
        chk("R4 dir after accept", int'(dir_o), 0);
        wait_done("R3");

        // R7 zero width acts as one
        issue(1'b0, 1'b0, 0, 1'b0, 0, "R7", a);
        wait_done("R7");

        // R5 + R6 reversal wait with fixed width
        issue(1'b1, 1'b0, 3, 1'b1, 0, "R5 R6 reversal", a);
        wait_done("R5");

        // R5 same direction, no wait
        issue(1'b1, 1'b1, 3, 1'b1, 0, "R5 same dir", a);
        wait_done("R5 same dir");

        // R8 queued request with its own direction
        issue(1'b0, 1'b0, 4, 1'b0, 0, "R8 first", a);
        issue(1'b1, 1'b0, 4, 1'b0, 0, "R8 queued", a2);
        chk("R8 queued accept edge", a2, a + 8);
        dir_in = 1'b0;
        wait_done("R8");

        // R10 width and mode changes mid-step ignored
        issue(1'b0, 1'b0, 6, 1'b0, 0, "R10", a);
        pw = PW_W'(20); trl = 1'b1;
        wait_done("R10");

        // R9 disable raised mid-pulse
        issue(1'b1, 1'b0, 10, 1'b0, 1, "R9", a);
        push_ev(a + 10, 1'b0, 1'b1, "R9 mid");
        push_ev(a + 12, 1'b1, 1'b1, "R9 mid");
        while (cyc < a + 11) @(negedge clk);
        dis = 1'b1;
        wait_done("R9 mid");
        chk("R9 dir unaffected", int'(dir_o), 1);

        // R9 disabled for a whole step
        issue(1'b0, 1'b0, 5, 1'b0, 0, "R9 full", a);
        chk("R9 dir still driven", int'(dir_o), 0);
        wait_done("R9 full");
        @(negedge clk);
        dis = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 scoreboard empty", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule